// File: doc/BRIEF.md
# Packed float-to-integer converter

This block takes a 128-bit operand made of four IEEE-754 single-precision numbers and turns each one into a signed 32-bit two's-complement integer. Each 32-bit slice is a lane, and every lane is converted independently of the others. A 2-bit rounding selector decides how a result that is not an exact integer is brought to an integer. Any value that cannot be represented comes out as the indefinite pattern 0x80000000; it is not clamped to a limit.

The block is a fixed-latency pipeline. An operation is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. After that, `in_ready` stays low for one cycle, so a new operation can enter at most every second cycle. Each result carries two flags, invalid and inexact, taken as the OR across the four lanes. An exception-mask input decides what happens when a lane is invalid. If the mask is clear and some lane is invalid, the block raises a fault and marks the result as not to be written back.

Top module: `fcvt_packed`

## Requirements
- R1: Lane k of the result (bits 32k+31 down to 32k) is the conversion of lane k of the operand, for k = 0..3. An operand whose value is already an integer inside the 32-bit signed range converts exactly and does not set inexact.
- R2: The value of `in_rc` selects the rounding of a value that is not an integer. 00 rounds to the nearest integer, with ties going to the even one. 01 rounds toward minus infinity. 10 rounds toward plus infinity. 11 truncates toward zero.
- R3: A lane that needed rounding sets `out_inexact`. Zero of either sign converts to 0. A denormal converts to 0 in every rounding mode, and a nonzero denormal sets `out_inexact`.
- R4: A lane whose rounded value lies outside -2^31 .. 2^31-1 returns 0x80000000 and sets `out_invalid`. So does any NaN and any infinity of either sign. Such a lane does not set inexact.
- R5: An operand equal to exactly -2^31 returns 0x80000000 and sets neither `out_invalid` nor `out_inexact`.
- R6: `out_invalid` and `out_inexact` are the OR of the per-lane conditions. They are valid in the same cycle as `out_data`, and they are low whenever `out_valid` is low.
- R7: `in_inv_mask` = 1 masks the invalid exception. When the mask is 0 and any lane is invalid, `out_fault` is 1 and `out_wr_en` is 0. Otherwise `out_wr_en` equals `out_valid` and `out_fault` is 0.
- R8: An operation accepted in cycle c shows its result, with `out_valid` high, in cycle c+5. Results leave in the order their operations were accepted.
- R9: In the cycle after an acceptance, `in_ready` is low, and `in_valid` in that cycle is ignored. `in_ready` then returns high. Holding `in_valid` high therefore yields one operation every 2 cycles.
- R10: While `rst` is high and after its release, `out_valid` is 0 and `in_ready` is 1 until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Block can accept an operation this cycle |
| in_data | input | 128 | Four packed single-precision operands |
| in_rc | input | 2 | Rounding selector (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| in_inv_mask | input | 1 | 1 masks the invalid exception |
| out_valid | output | 1 | Result present |
| out_data | output | 128 | Four packed signed 32-bit integers |
| out_invalid | output | 1 | Some lane was invalid |
| out_inexact | output | 1 | Some lane was rounded |
| out_fault | output | 1 | Unmasked invalid exception |
| out_wr_en | output | 1 | Result may be written to its destination |

## Verification
The bench walks every biased exponent from 0 to 255. It pairs each exponent with fractions that give exact integers, exact halves and quarters, and all-ones patterns, in both signs and under all four rounding selections. This separates the shift-left path, the shift-right-and-round path, the denormal path, the saturation boundary at 2^31, and the NaN and infinity encodings. Directed operands then pin down the cases that sit on a boundary: ties such as ±2.5 and 0.5, exactly -2^31 against +2^31, and the largest in-range float. These are tried with the mask both set and clear, which tells a masked invalid result apart from a faulting one. All operations are streamed with `in_valid` held high, so the ignored cycle after each acceptance and the five-cycle latency are exercised on every operation.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;
    localparam int MANT_W = FRAC_W + 1;
    localparam int WIDE_W = MANT_W + WORD_W;

    // biased exponent at which the value is 2^(WORD_W-1)
    localparam logic [EXP_W-1:0] EXP_SAT   = EXP_W'(BIAS + WORD_W - 1);
    // biased exponent at which the mantissa LSB weighs exactly 1
    localparam logic [EXP_W-1:0] EXP_UNITY = EXP_W'(BIAS + FRAC_W);
    localparam logic [EXP_W-1:0] EXP_SPEC  = {EXP_W{1'b1}};
    // beyond this right shift the magnitude is below one half
    localparam logic [EXP_W-1:0] RSH_CAP   = EXP_W'(MANT_W + 1);

    localparam logic [WORD_W-1:0] INDEF = {1'b1, {(WORD_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              invalid;
        logic              inexact;
    } lane_res_t;

    // decide whether the magnitude is bumped by one
    function automatic logic round_bump(rc_e rc, logic neg, logic lsb,
                                        logic half, logic rest);
        case (rc)
            RC_NEAR: return half & (rest | lsb);
            RC_DOWN: return neg & (half | rest);
            RC_UP:   return ~neg & (half | rest);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fcvt_lane.sv
module fcvt_lane
    import fcvt_pkg::*;
(
    input  logic [WORD_W-1:0] bits_i,
    input  rc_e               rc_i,
    output lane_res_t         res_o
);

    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  rsh;
    logic [WIDE_W-1:0] wide;
    logic [MANT_W-1:0] ipart;
    logic              half;
    logic              rest;
    logic              bump;
    logic [WORD_W-1:0] mag;

    assign sign = bits_i[WORD_W-1];
    assign expo = bits_i[WORD_W-2 -: EXP_W];
    assign frac = bits_i[FRAC_W-1:0];
    assign mant = {1'b1, frac};

    always_comb begin
        res_o = '0;
        rsh   = '0;
        wide  = '0;
        ipart = '0;
        half  = 1'b0;
        rest  = 1'b0;
        bump  = 1'b0;
        mag   = '0;
        if (expo == EXP_SPEC) begin
            res_o.value   = INDEF;
            res_o.invalid = 1'b1;
        end else if (expo == '0) begin
            res_o.inexact = |frac;
        end else if (expo >= EXP_SAT) begin
            // only -2^31 itself is representable up here
            res_o.value   = INDEF;
            res_o.invalid = !(expo == EXP_SAT && frac == '0 && sign);
        end else if (expo >= EXP_UNITY) begin
            mag         = WORD_W'(mant) << (expo - EXP_UNITY);
            res_o.value = sign ? -mag : mag;
        end else begin
            rsh = EXP_UNITY - expo;
            if (rsh > RSH_CAP) rsh = RSH_CAP;
            wide  = {mant, {WORD_W{1'b0}}} >> rsh;
            ipart = wide[WIDE_W-1 -: MANT_W];
            half  = wide[WORD_W-1];
            rest  = |wide[WORD_W-2:0];
            bump  = round_bump(rc_i, sign, ipart[0], half, rest);
            mag   = WORD_W'(ipart) + WORD_W'(bump);
            res_o.value   = sign ? -mag : mag;
            res_o.inexact = half | rest;
        end
    end

endmodule

// File: rtl/fcvt_issue.sv
module fcvt_issue #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic rdy_o,
    output logic take_o
);

    localparam int CW = $clog2(GAP) + 1;

    logic [CW-1:0] hold_q;

    assign rdy_o  = (hold_q == '0);
    assign take_o = req_i & rdy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (take_o) begin
            hold_q <= CW'(GAP - 1);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/fcvt_pipe.sv
module fcvt_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else if (i == 0) begin
                stage_q[i] <= d_i;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/fcvt_packed.sv
module fcvt_packed
    import fcvt_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int LATENCY   = 5,
    parameter int ISSUE_GAP = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*WORD_W-1:0] in_data,
    input  logic [1:0]              in_rc,
    input  logic                    in_inv_mask,
    output logic                    out_valid,
    output logic [LANES*WORD_W-1:0] out_data,
    output logic                    out_invalid,
    output logic                    out_inexact,
    output logic                    out_fault,
    output logic                    out_wr_en
);

    localparam int DATA_W = LANES * WORD_W;
    localparam int PACK_W = DATA_W + 4;
    localparam int TAIL   = LATENCY - 1;

    logic              take;
    logic              s1_vld;
    logic [DATA_W-1:0] s1_data;
    rc_e               s1_rc;
    logic              s1_mask;

    lane_res_t         lane_res [LANES];
    logic [DATA_W-1:0] conv_data;
    logic              any_inv;
    logic              any_inx;
    logic [PACK_W-1:0] conv_pack;
    logic [PACK_W-1:0] tail_q;

    fcvt_issue #(.GAP(ISSUE_GAP)) u_issue (
        .clk   (clk),
        .rst   (rst),
        .req_i (in_valid),
        .rdy_o (in_ready),
        .take_o(take)
    );

    always_ff @(posedge clk) begin
        if (rst) s1_vld <= 1'b0;
        else     s1_vld <= take;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            s1_data <= in_data;
            s1_rc   <= rc_e'(in_rc);
            s1_mask <= in_inv_mask;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fcvt_lane u_lane (
            .bits_i(s1_data[g*WORD_W +: WORD_W]),
            .rc_i  (s1_rc),
            .res_o (lane_res[g])
        );
        assign conv_data[g*WORD_W +: WORD_W] = lane_res[g].value;
    end

    always_comb begin
        any_inv = 1'b0;
        any_inx = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            any_inv = any_inv | lane_res[i].invalid;
            any_inx = any_inx | lane_res[i].inexact;
        end
    end

    assign conv_pack = {s1_vld,
                        s1_vld & any_inv & ~s1_mask,
                        s1_vld & any_inv,
                        s1_vld & any_inx,
                        conv_data};

    fcvt_pipe #(.W(PACK_W), .DEPTH(TAIL)) u_tail (
        .clk(clk),
        .rst(rst),
        .d_i(conv_pack),
        .q_o(tail_q)
    );

    assign {out_valid, out_fault, out_invalid, out_inexact, out_data} = tail_q;
    assign out_wr_en = out_valid & ~out_fault;

endmodule

// File: rtl/fcvt_packed_chk.sv
module fcvt_packed_chk
    import fcvt_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LATENCY = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic [LANES*WORD_W-1:0] out_data,
    input logic                    out_invalid,
    input logic                    out_inexact,
    input logic                    out_fault,
    input logic                    out_wr_en
);

    logic [LATENCY-1:0] acc_sr;
    logic               has_indef;

    always_ff @(posedge clk) begin
        if (rst) acc_sr <= '0;
        else     acc_sr <= {acc_sr[LATENCY-2:0], in_valid & in_ready};
    end

    always_comb begin
        has_indef = 1'b0;
        for (int i = 0; i < LANES; i++)
            has_indef = has_indef | (out_data[i*WORD_W +: WORD_W] == INDEF);
    end

    a_r8_latency_tracks_accepts: assert property (@(posedge clk) disable iff (rst)
        out_valid == acc_sr[LATENCY-1]);

    a_r9_gap_after_accept: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);

    a_r6_quiet_flags_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_invalid || out_inexact || out_fault || out_wr_en));

    a_r7_fault_blocks_write: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> out_valid && out_invalid && !out_wr_en);

    a_r7_write_when_clean: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_invalid |-> out_wr_en);

    a_r4_invalid_has_indef_lane: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_invalid |-> has_indef);

endmodule

bind fcvt_packed fcvt_packed_chk #(.LANES(LANES), .LATENCY(LATENCY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_invalid(out_invalid),
    .out_inexact(out_inexact),
    .out_fault  (out_fault),
    .out_wr_en  (out_wr_en)
);

// File: tb/fcvt_packed_bench.sv
module fcvt_packed_bench;

    localparam int LANES = 4;
    localparam int LAT   = 5;
    localparam logic [31:0] IND = 32'h8000_0000;
    localparam longint IMAX = 64'sd2147483647;
    localparam longint IMIN = -64'sd2147483648;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic [1:0]   in_rc = '0;
    logic         in_inv_mask = 1'b1;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_invalid;
    logic         out_inexact;
    logic         out_fault;
    logic         out_wr_en;

    fcvt_packed u_fcvt_packed (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_rc(in_rc), .in_inv_mask(in_inv_mask),
        .out_valid(out_valid), .out_data(out_data),
        .out_invalid(out_invalid), .out_inexact(out_inexact),
        .out_fault(out_fault), .out_wr_en(out_wr_en)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [127:0] q_data [$];
    bit           q_inv  [$];
    bit           q_inx  [$];
    bit           q_flt  [$];
    int           q_cyc  [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // arithmetic reference: integer division instead of shifting
    task automatic ref_lane(input logic [31:0] x, input logic [1:0] rc,
                            output logic [31:0] v, output bit inv, output bit inx);
        longint mant, den, q, r, mag, sv;
        int ex, cmp;
        bit up;
        inv = 0; inx = 0; v = '0;
        ex = int'(x[30:23]);
        if (ex == 255) begin
            v = IND; inv = 1;
        end else if (ex == 0) begin
            inx = (x[22:0] != 0);
        end else begin
            mant = longint'({1'b1, x[22:0]});
            ex = ex - 127;
            if (ex >= 40) begin
                v = IND; inv = 1;
            end else begin
                if (ex >= 23) begin
                    q = mant <<< (ex - 23); r = 0; cmp = -1;
                end else if (ex >= -38) begin
                    den = longint'(1) <<< (23 - ex);
                    q = mant / den; r = mant % den;
                    cmp = (2*r > den) ? 1 : ((2*r == den) ? 0 : -1);
                end else begin
                    q = 0; r = 1; cmp = -1;
                end
                inx = (r != 0);
                case (rc)
                    2'b00:   up = (cmp > 0) || (cmp == 0 && q[0]);
                    2'b01:   up = inx && x[31];
                    2'b10:   up = inx && !x[31];
                    default: up = 0;
                endcase
                mag = q + (up ? 64'sd1 : 64'sd0);
                sv  = x[31] ? -mag : mag;
                if (sv > IMAX || sv < IMIN) begin
                    v = IND; inv = 1; inx = 0;
                end else begin
                    v = sv[31:0];
                end
            end
        end
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic issue(input logic [127:0] d, input logic [1:0] rc, input bit m);
        logic [127:0] ed;
        logic [31:0]  lv;
        bit li, lx, ai, ax;
        in_valid = 1; in_data = d; in_rc = rc; in_inv_mask = m;
        while (!in_ready) @(negedge clk);
        ai = 0; ax = 0; ed = '0;
        for (int l = 0; l < LANES; l++) begin
            ref_lane(d[l*32 +: 32], rc, lv, li, lx);
            ed[l*32 +: 32] = lv;
            ai |= li; ax |= lx;
        end
        q_data.push_back(ed); q_inv.push_back(ai); q_inx.push_back(ax);
        q_flt.push_back(ai && !m); q_cyc.push_back(cyc);
        @(negedge clk);
        chk(in_ready == 1'b0, "R9", "ready after accept", {127'b0, in_ready}, 128'd0);
    endtask

    function automatic logic [31:0] sweep_val(input int idx);
        logic [22:0] f;
        case ((idx >> 1) % 6)
            0: f = 23'h000000;
            1: f = 23'h000001;
            2: f = 23'h400000;
            3: f = 23'h200000;
            4: f = 23'h7FFFFF;
            default: f = 23'h2AAAAA;
        endcase
        return {idx[0], 8'(idx / 12), f};
    endfunction

    // result monitor
    always @(negedge clk) begin
        logic [127:0] ed;
        bit ei, ex, ef;
        int ec;
        if (!rst && out_valid) begin
            if (q_data.size() == 0) begin
                chk(0, "R9", "result without accepted op", 128'd1, 128'd0);
            end else begin
                ed = q_data.pop_front(); ei = q_inv.pop_front();
                ex = q_inx.pop_front(); ef = q_flt.pop_front(); ec = q_cyc.pop_front();
                chk(out_data == ed, "R1 R2 R3 R4 R5", "lane data", out_data, ed);
                chk({out_invalid, out_inexact} == {ei, ex}, "R3 R6", "flags",
                    {126'b0, out_invalid, out_inexact}, {126'b0, ei, ex});
                chk({out_fault, out_wr_en} == {ef, !ef}, "R7", "fault/write",
                    {126'b0, out_fault, out_wr_en}, {126'b0, ef, !ef});
                chk(cyc - ec == LAT, "R8", "latency", 128'(cyc - ec), 128'(LAT));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "valid in reset", {127'b0, out_valid}, 128'd0);
        chk(in_ready == 1'b1, "R10", "ready in reset", {127'b0, in_ready}, 128'd1);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "valid after reset", {127'b0, out_valid}, 128'd0);
        chk(in_ready == 1'b1, "R10", "ready after reset", {127'b0, in_ready}, 128'd1);

        // exponent sweep, all rounding modes, mask alternating
        for (int rc = 0; rc < 4; rc++) begin
            for (int op = 0; op < 768; op++) begin
                for (int l = 0; l < LANES; l++) d[l*32 +: 32] = sweep_val(op*4 + l);
                issue(d, 2'(rc), op[0]);
            end
        end

        // directed boundary operands
        for (int rc = 0; rc < 4; rc++) begin
            for (int m = 0; m < 2; m++) begin
                issue({32'hBFC00000, 32'h3F000000, 32'hC0200000, 32'h40200000}, 2'(rc), m[0]);
                issue({32'hFF800000, 32'h7FC00000, 32'h4F000000, 32'hCF000000}, 2'(rc), m[0]);
                issue({32'h3F800000, 32'h80000000, 32'h00000001, 32'h4EFFFFFF}, 2'(rc), m[0]);
                issue({32'h3F800000, 32'hCF000000, 32'h80000000, 32'h3EFFFFFF}, 2'(rc), m[0]);
                issue({32'h7F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000}, 2'(rc), m[0]);
            end
        end

        in_valid = 0;
        repeat (LAT + 5) @(negedge clk);
        chk(q_data.size() == 0, "R8", "outstanding results", 128'(q_data.size()), 128'd0);
        chk(in_ready == 1'b1, "R9", "ready when idle", {127'b0, in_ready}, 128'd1);
        finish_run();
    end

endmodule